// File: doc/BRIEF.md
# Status Packet Byte Sender

This block sends a status word to a downstream collector as a short burst of bytes on an 8-bit bus. A send pulse, or an automatic trigger, starts a packet. The block captures the status word and a caller-supplied 6-bit sequence tag, then raises a request line and waits for the collector. The collector grants the bus by pulsing an acknowledge. The address byte is on the bus during that acknowledge cycle. The remaining bytes follow on the next consecutive clocks with no further handshake.

Each packet has a fixed layout. The leading byte is a constant address chosen by parameter. The next byte carries the sequence tag in its upper six bits and status bits 1:0 in its lower two. The trailing bytes carry the rest of the status word as 8-bit slices, starting at status bit 2. The status width is a parameter, and a narrower word gives a shorter packet. A send that arrives while a packet is in flight is remembered and served after that packet. In automatic mode, a packet goes out each time the status input differs from the word last sent.

Top module: `stx_status_tx`

## Requirements
- R1: While reset is held and after it is released, `pkt_req` is 0 and `pkt_byte` is 0 until a trigger arrives.
- R2: A `send` pulse seen while idle raises `pkt_req` on the next cycle. `pkt_req` then stays high for every cycle in which `ack` is low.
- R3: In the cycle where `pkt_req` and `ack` are both high, `pkt_byte` equals the `STAT_ADDR` parameter. `pkt_req` is low from the next cycle on.
- R4: On the cycle after the acknowledge, `pkt_byte` is `{seq[5:0], status[1:0]}`, with the sequence tag in bits 7:2.
- R5: Byte k (k >= 2) follows on the next consecutive cycle and equals status bits [2+8*(k-2) +: 8]. Bits above `STAT_W-1` read as 0.
- R6: A packet is 2 + ceil((STAT_W-2)/8) bytes long, which is 5 for the default width of 26. On the cycle after the last byte, `pkt_byte` is 0 and `pkt_req` is 0.
- R7: `pkt_byte` is 0 in every cycle that carries no packet byte, including the cycles spent waiting for `ack`.
- R8: The status word and sequence tag are sampled on the clock edge that starts the packet. Later changes to `stat_word` or `seq_num` do not alter that packet's bytes.
- R9: A `send` pulse during a packet is held pending. After the last byte, exactly one idle cycle follows, then `pkt_req` rises and the packet carries the inputs present on that starting edge.
- R10: With `auto_en` high and the sender idle, a packet starts when `stat_word` differs from the word last captured. No packet starts while they are equal. The reference word resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stat_word | input | STAT_W | Status word to report |
| seq_num | input | 6 | Sequence tag placed in byte 1 |
| send | input | 1 | Request one packet |
| auto_en | input | 1 | Send automatically whenever the status word changes |
| ack | input | 1 | Collector grant; the address byte is taken on this cycle |
| pkt_req | output | 1 | Request to send a packet |
| pkt_byte | output | 8 | Packet byte bus, 0 when no byte is sent |

## Verification
The checker watches every cycle for several properties. It checks that the request holds until the grant and falls right after it. It checks that the address byte is on the bus during the grant and that the tag/low-bits byte comes next. It checks that the bus stays zero outside a packet and that the captured word stays stable while a packet is in flight. Some behaviours show only in the bench's scenarios, which compare every byte against a model. These are the full byte order and zero padding of the trailing slices, the collapse of a send made mid-packet into one later packet with its one-cycle gap, and the automatic mode's refusal to resend an unchanged word.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } stx_state_e;

  localparam int unsigned SEQ_W = 6;

  // Bytes per packet: address, tag/low-bits byte, then 8-bit slices from bit 2.
  function automatic int unsigned stx_num_bytes(input int unsigned stat_w);
    return 2 + (stat_w + 5) / 8;
  endfunction

endpackage

// File: rtl/stx_trigger.sv
module stx_trigger #(
  parameter int unsigned STAT_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              send,
  input  logic              auto_en,
  input  logic [STAT_W-1:0] stat_word,
  output logic              start
);

  logic              pend_q, pend_d;
  logic [STAT_W-1:0] last_q, last_d;
  logic              last_en;
  logic              auto_hit;

  always_comb begin
    auto_hit = auto_en && (stat_word != last_q);
    start    = idle && (send || pend_q || auto_hit);
    if (start)
      pend_d = 1'b0;
    else if (send)
      pend_d = 1'b1;
    else
      pend_d = pend_q;
    last_en = start;
    last_d  = stat_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/stx_capture.sv
module stx_capture #(
  parameter int unsigned STAT_W = 26,
  parameter int unsigned SEQ_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STAT_W-1:0] stat_word,
  input  logic [SEQ_W-1:0]  seq_num,
  output logic [STAT_W-1:0] cap_word,
  output logic [SEQ_W-1:0]  cap_seq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_word <= '0;
      cap_seq  <= '0;
    end else if (load) begin
      cap_word <= stat_word;
      cap_seq  <= seq_num;
    end
  end

endmodule

// File: rtl/stx_sequencer.sv
module stx_sequencer
  import stx_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 5,
  localparam int unsigned IDX_W = $clog2(NUM_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ack,
  output logic             idle,
  output logic             req,
  output logic             active,
  output logic [IDX_W-1:0] sel
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  stx_state_e       st_q, st_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (ack) begin
          st_d   = ST_SEND;
          cnt_d  = IDX_W'(1);
          cnt_en = 1'b1;
        end
      end
      ST_SEND: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST_IDX) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + IDX_W'(1);
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    idle   = (st_q == ST_IDLE);
    req    = (st_q == ST_WAIT);
    active = (st_q == ST_SEND) || ((st_q == ST_WAIT) && ack);
    sel    = (st_q == ST_SEND) ? cnt_q : '0;
  end

endmodule

// File: rtl/stx_byte_mux.sv
module stx_byte_mux #(
  parameter int unsigned STAT_W    = 26,
  parameter int unsigned SEQ_W     = 6,
  parameter int unsigned NUM_BYTES = 5,
  parameter logic [7:0]  STAT_ADDR = 8'h3C,
  localparam int unsigned IDX_W = $clog2(NUM_BYTES),
  localparam int unsigned PAD_W = 8 * (NUM_BYTES - 2) + 2
) (
  input  logic              active,
  input  logic [IDX_W-1:0]  sel,
  input  logic [STAT_W-1:0] cap_word,
  input  logic [SEQ_W-1:0]  cap_seq,
  output logic [7:0]        pkt_byte
);

  logic [PAD_W-1:0] padded;
  logic [7:0]       bytes [NUM_BYTES];

  assign padded   = PAD_W'(cap_word);
  assign bytes[0] = STAT_ADDR;
  assign bytes[1] = {cap_seq, padded[1:0]};

  for (genvar k = 2; k < NUM_BYTES; k++) begin : g_slice
    assign bytes[k] = padded[2 + 8 * (k - 2) +: 8];
  end

  always_comb begin
    pkt_byte = 8'h00;
    if (active) begin
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (sel == IDX_W'(k)) pkt_byte = bytes[k];
      end
    end
  end

endmodule

// File: rtl/stx_status_tx.sv
module stx_status_tx
  import stx_pkg::*;
#(
  parameter int unsigned STAT_W    = 26,
  parameter logic [7:0]  STAT_ADDR = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_word,
  input  logic [5:0]        seq_num,
  input  logic              send,
  input  logic              auto_en,
  input  logic              ack,
  output logic              pkt_req,
  output logic [7:0]        pkt_byte
);

  localparam int unsigned NUM_BYTES = stx_num_bytes(STAT_W);
  localparam int unsigned IDX_W     = $clog2(NUM_BYTES);

  logic              rst_s1, rst_sync_n;
  logic              idle, start, active;
  logic [IDX_W-1:0]  sel;
  logic [STAT_W-1:0] cap_word;
  logic [SEQ_W-1:0]  cap_seq;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  stx_trigger #(.STAT_W(STAT_W)) i_trigger (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .idle      (idle),
    .send      (send),
    .auto_en   (auto_en),
    .stat_word (stat_word),
    .start     (start)
  );

  stx_capture #(.STAT_W(STAT_W), .SEQ_W(SEQ_W)) i_capture (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (start),
    .stat_word (stat_word),
    .seq_num   (seq_num),
    .cap_word  (cap_word),
    .cap_seq   (cap_seq)
  );

  stx_sequencer #(.NUM_BYTES(NUM_BYTES)) i_sequencer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .ack    (ack),
    .idle   (idle),
    .req    (pkt_req),
    .active (active),
    .sel    (sel)
  );

  stx_byte_mux #(
    .STAT_W    (STAT_W),
    .SEQ_W     (SEQ_W),
    .NUM_BYTES (NUM_BYTES),
    .STAT_ADDR (STAT_ADDR)
  ) i_byte_mux (
    .active   (active),
    .sel      (sel),
    .cap_word (cap_word),
    .cap_seq  (cap_seq),
    .pkt_byte (pkt_byte)
  );

endmodule

// File: rtl/stx_status_tx_chk.sv
module stx_status_tx_chk #(
  parameter int unsigned STAT_W    = 26,
  parameter logic [7:0]  STAT_ADDR = 8'h3C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              pkt_req,
  input logic [7:0]        pkt_byte,
  input logic              active,
  input logic [STAT_W-1:0] cap_word,
  input logic [5:0]        cap_seq
);

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_req && !ack) |=> pkt_req); // R2

  AST_REQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_req && ack) |=> !pkt_req); // R3

  AST_ADDR_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_req && ack) |-> (pkt_byte == STAT_ADDR)); // R3

  AST_TAG_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_req && ack) |-> (pkt_byte == {cap_seq, cap_word[1:0]})); // R4

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (pkt_byte == 8'h00)); // R7

  AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(cap_word) && $stable(cap_seq))); // R8

endmodule

bind stx_status_tx stx_status_tx_chk #(
  .STAT_W    (STAT_W),
  .STAT_ADDR (STAT_ADDR)
) i_stx_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .pkt_req  (pkt_req),
  .pkt_byte (pkt_byte),
  .active   (active),
  .cap_word (cap_word),
  .cap_seq  (cap_seq)
);

// File: tb/test_stx_status_tx.sv
`timescale 1ns/1ps
module test_stx_status_tx;

  localparam int          CLK_PERIOD = 10;
  localparam int          STAT_W     = 26;
  localparam logic [7:0]  ADDR       = 8'hA7;
  localparam int          NB         = 2 + (STAT_W - 2 + 7) / 8; // R6 length formula

  logic              clk = 1'b0;
  logic              rst_n;
  logic [STAT_W-1:0] stat_word;
  logic [5:0]        seq_num;
  logic              send, auto_en, ack;
  logic              pkt_req;
  logic [7:0]        pkt_byte;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stx_status_tx #(.STAT_W(STAT_W), .STAT_ADDR(ADDR)) i_stx_status_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_word (stat_word),
    .seq_num   (seq_num),
    .send      (send),
    .auto_en   (auto_en),
    .ack       (ack),
    .pkt_req   (pkt_req),
    .pkt_byte  (pkt_byte)
  );

  function automatic logic [7:0] exp_byte(input int k, input logic [STAT_W-1:0] w,
                                          input logic [5:0] s);
    logic [63:0] wide;
    wide = 64'(w);
    if (k == 0) return ADDR;
    if (k == 1) return {s, w[1:0]};
    wide = wide >> (2 + 8 * (k - 2));
    return wide[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Entered at a negedge where the request is expected high.
  task automatic handshake(input logic [STAT_W-1:0] w, input logic [5:0] s,
                           input int delay, input bit scramble, input int pend_at,
                           input logic [STAT_W-1:0] nw, input logic [5:0] ns);
    chk(pkt_req == 1'b1, "R2", 32'(pkt_req), 1);
    chk(pkt_byte == 8'h00, "R7", 32'(pkt_byte), 0);
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      chk(pkt_req == 1'b1, "R2", 32'(pkt_req), 1);
      chk(pkt_byte == 8'h00, "R7", 32'(pkt_byte), 0);
    end
    ack = 1'b1;
    #1;
    chk(pkt_byte == ADDR, "R3", 32'(pkt_byte), 32'(ADDR));
    for (int k = 1; k < NB; k++) begin
      @(negedge clk);
      if (k == 1) ack = 1'b0;
      send = 1'b0;
      if (scramble) begin
        stat_word = STAT_W'($urandom);
        seq_num   = 6'($urandom);
      end
      if (k == pend_at) begin
        send      = 1'b1;
        stat_word = nw;
        seq_num   = ns;
      end
      #1;
      chk(pkt_byte == exp_byte(k, w, s), (k == 1) ? "R4" : "R5",
          32'(pkt_byte), 32'(exp_byte(k, w, s)));
      chk(pkt_req == 1'b0, "R3", 32'(pkt_req), 0);
    end
    @(negedge clk);
    send = 1'b0;
    chk(pkt_byte == 8'h00, "R6", 32'(pkt_byte), 0);
    chk(pkt_req == 1'b0, "R6", 32'(pkt_req), 0);
  endtask

  task automatic fire(input logic [STAT_W-1:0] w, input logic [5:0] s, input int delay,
                      input bit scramble);
    stat_word = w;
    seq_num   = s;
    send      = 1'b1;
    @(negedge clk);
    send = 1'b0;
    handshake(w, s, delay, scramble, -1, '0, '0);
  endtask

  initial begin
    logic [STAT_W-1:0] w, w2;
    logic [5:0]        s, s2;
    void'($urandom(32'd4711));
    rst_n = 1'b0; stat_word = '0; seq_num = '0;
    send = 1'b0; auto_en = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(pkt_req == 1'b0, "R1", 32'(pkt_req), 0);
    chk(pkt_byte == 8'h00, "R1", 32'(pkt_byte), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(pkt_req == 1'b0, "R1", 32'(pkt_req), 0);
      chk(pkt_byte == 8'h00, "R1", 32'(pkt_byte), 0);
    end

    // Directed corners: all ones, all zeros, alternating, long wait for grant.
    fire({STAT_W{1'b1}}, 6'h3F, 0, 1'b0);
    fire('0, 6'h00, 1, 1'b0);
    fire(STAT_W'(32'h02AA_AAAA), 6'h15, 7, 1'b1);
    fire(STAT_W'(32'h0155_5555), 6'h2A, 0, 1'b1);

    // Constrained random packets with random grant delays; inputs scrambled after capture (R8).
    for (int i = 0; i < 40; i++) begin
      fire(STAT_W'($urandom), 6'($urandom), int'($urandom_range(0, 4)), 1'b1);
    end

    // R9: send during a packet is held, one idle cycle, then a request.
    for (int p = 1; p < NB; p++) begin
      w = STAT_W'($urandom); s = 6'($urandom);
      w2 = STAT_W'($urandom); s2 = 6'($urandom);
      stat_word = w; seq_num = s; send = 1'b1;
      @(negedge clk);
      send = 1'b0;
      handshake(w, s, p % 3, 1'b0, p, w2, s2);
      @(negedge clk);
      chk(pkt_req == 1'b1, "R9", 32'(pkt_req), 1);
      handshake(w2, s2, 0, 1'b0, -1, '0, '0);
      for (int q = 0; q < 3; q++) begin
        @(negedge clk);
        chk(pkt_req == 1'b0, "R9", 32'(pkt_req), 0);
      end
    end

    // R10: automatic mode sends on change only.
    w = STAT_W'(32'h0123_4567);
    if (w == stat_word) w = ~w;
    stat_word = w; seq_num = 6'h09; auto_en = 1'b1;
    @(negedge clk);
    chk(pkt_req == 1'b1, "R10", 32'(pkt_req), 1);
    handshake(w, 6'h09, 2, 1'b0, -1, '0, '0);
    for (int q = 0; q < 8; q++) begin
      @(negedge clk);
      chk(pkt_req == 1'b0, "R10", 32'(pkt_req), 0);
    end
    w2 = w ^ STAT_W'(1);
    stat_word = w2; seq_num = 6'h31;
    @(negedge clk);
    chk(pkt_req == 1'b1, "R10", 32'(pkt_req), 1);
    handshake(w2, 6'h31, 0, 1'b0, -1, '0, '0);
    auto_en = 1'b0;
    stat_word = ~w2;
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      chk(pkt_req == 1'b0, "R10", 32'(pkt_req), 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule